// File: doc/BRIEF.md
# Write-Only Two-Wire Target Receiver

This block is a receive-only target on an I2C bus. A fast system clock samples SCL and SDA and finds start and stop conditions. After a start it collects the address byte. The address is accepted only if its upper seven bits equal the `DEV_ADDR` parameter and its read/write bit is 0. When the address is accepted, the block acknowledges it. It then acknowledges every byte that follows and hands each one to the core logic as soon as its eighth bit has been clocked in. It has no register pointer and no subaddress: every byte after the address is streamed out in bus order until a stop. Reads, clock stretching and 10-bit addressing are not supported.

The controller is a single state machine with these states:
- `ST_IDLE`: the bus is free or the transfer has ended.
- `ST_ADDR`: shifting in the address byte.
- `ST_DATA`: shifting in a data byte.
- `ST_ACK_LO`: SDA is pulled low and the block waits for the acknowledge clock to rise.
- `ST_ACK_HI`: SDA is still pulled low and the block waits for that clock to fall.
- `ST_SKIP`: the transfer is not for this target and the bus is ignored.

Transitions:
- A start moves any state to `ST_ADDR`.
- A stop moves any state to `ST_IDLE`.
- `ST_ADDR` moves on the SCL fall after the eighth bit, to `ST_ACK_LO` on a match or to `ST_SKIP` otherwise.
- `ST_DATA` moves on the SCL fall after the eighth bit to `ST_ACK_LO`, and fires the byte strobe.
- `ST_ACK_LO` moves to `ST_ACK_HI` on an SCL rise.
- `ST_ACK_HI` moves to `ST_DATA` on an SCL fall, which releases SDA.

Both lines pass through synchronizers. The system clock must run at least 20 times faster than SCL.

Top module: `i2c_wr_target`

## Requirements
- R1: A start (SDA falling while SCL is high) sets `busy_o`. A stop (SDA rising while SCL is high) clears `busy_o` and releases SDA.
- R2: An address byte whose upper seven bits, sent MSB first, equal `DEV_ADDR` and whose eighth bit is 0 is acknowledged. SDA is held low for the whole high phase of the ninth clock, and `busy_o` stays high.
- R3: An address byte with any other upper seven bits is not acknowledged. `busy_o` drops, and no byte is acknowledged or delivered until the next start.
- R4: An address byte matching `DEV_ADDR` but with the eighth (read/write) bit set to 1 is not acknowledged, and the following bytes are neither acknowledged nor delivered.
- R5: Each complete data byte is presented on `rx_data_o`, first received bit in bit 7, with `rx_valid_o` high for exactly one cycle. The strobe appears once per byte, at the SCL fall that ends the eighth bit.
- R6: Every data byte of an accepted transfer is acknowledged, whatever the number of bytes.
- R7: A data byte cut short by a stop before its eighth bit produces no strobe.
- R8: A repeated start abandons any partial byte and restarts address reception. The new address is judged on its own.
- R9: After reset, `sda_pull_o`, `busy_o` and `rx_valid_o` are 0.
- R10: The SDA pull-down starts only while SCL is low and is released at the SCL fall ending the acknowledge clock, so the controller can drive the next bit, including a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain enable) |
| busy_o | output | 1 | Transaction active |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
The hardest case to reach from the ports is a stop or a repeated start landing mid-byte. For that, the SDA level the controller sends just before the condition must itself clock in as a bit, which leaves a partial byte in the shifter. The bench builds these sequences bit by bit: five bits and then a stop, and three bits and then a restart. It then counts strobes. It also sweeps every 7-bit address, and sends a run of all 256 byte values to a single accepted transfer. After each acknowledge the controller drives a 1 on the next bit, so a pull-down released late shows up as corrupted data.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // conditions need SCL high on both samples so an SCL edge is never mistaken
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
    assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift
    import i2c_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full_o
);
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sreg <= '0;
        end else if (clear) begin
            cnt  <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[BYTE_W-2:0], bit_in};
            cnt  <= cnt + 1'b1;
        end
    end

    assign byte_o = sreg;
    assign full_o = (cnt == CNT_W'(BYTE_W));

    // R5
    shift_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (cnt < CNT_W'(BYTE_W)));
    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !full_o);
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              busy_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, ev_start, ev_stop;
    logic [BYTE_W-1:0] byte_q;
    logic full;
    logic addr_ok;
    logic sh_clear, sh_en;
    rx_state_t st, nxt;

    assign line_raw = {sda_i, scl_i};

    generate
        for (genvar gi = 0; gi < NLINES; gi++) begin : g_sync
            i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk (clk),
                .rst_n (rst_n),
                .din (line_raw[gi]),
                .dout (line_s[gi])
            );
        end
    endgenerate

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    assign sh_clear = ev_start || (st == ST_IDLE) || (st == ST_ACK_HI && scl_fall);
    assign sh_en    = scl_rise && !full && (st == ST_ADDR || st == ST_DATA);

    i2c_rx_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .shift_en (sh_en),
        .bit_in   (sda_s),
        .byte_o   (byte_q),
        .full_o   (full)
    );

    assign addr_ok = (byte_q[BYTE_W-1:1] == DEV_ADDR) && !byte_q[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (ev_start) begin
            nxt = ST_ADDR;
        end else if (ev_stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   nxt = ST_IDLE;
                ST_ADDR:   if (scl_fall && full) nxt = addr_ok ? ST_ACK_LO : ST_SKIP;
                ST_DATA:   if (scl_fall && full) nxt = ST_ACK_LO;
                ST_ACK_LO: if (scl_rise) nxt = ST_ACK_HI;
                ST_ACK_HI: if (scl_fall) nxt = ST_DATA;
                ST_SKIP:   nxt = ST_SKIP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            busy_o     <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            sda_pull_o <= (nxt == ST_ACK_LO) || (nxt == ST_ACK_HI);
            rx_valid_o <= (st == ST_DATA) && (nxt == ST_ACK_LO);
            if ((st == ST_DATA) && (nxt == ST_ACK_LO)) rx_data_o <= byte_q;
            if (ev_start)              busy_o <= 1'b1;
            else if (ev_stop)          busy_o <= 1'b0;
            else if (nxt == ST_SKIP)   busy_o <= 1'b0;
        end
    end

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!busy_o && !sda_pull_o));
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (busy_o && !sda_pull_o && !rx_valid_o));
    // R3
    quiet_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sda_pull_o);
    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
    // R6
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> sda_pull_o);
    // R10
    pull_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);
endmodule

// File: tb/sim_i2c_wr_target.sv
`timescale 1ns/1ps
module sim_i2c_wr_target;
    localparam logic [6:0] DEV = 7'h4A;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull, busy, rx_valid;
    logic [7:0] rx_data;
    wire sda_line = m_sda & ~sda_pull;

    int errors = 0;
    int checks = 0;
    int ngot = 0;
    logic [7:0] got [0:511];
    logic prev_valid = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_wr_target #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u0 (
        .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_line),
        .sda_pull_o (sda_pull), .busy_o (busy),
        .rx_data_o (rx_data), .rx_valid_o (rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && ngot < 512) begin
                got[ngot] = rx_data;
            end
            if (rx_valid) ngot++;
            if (rx_valid && prev_valid) begin
                errors++;
                $display("FAIL R5: strobe high two cycles, got 1 expected 0");
            end
            prev_valid = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_cond();
        if (m_scl == 1'b0) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
        end
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    // returns 1 when SDA was low at both ends of the ninth clock high phase
    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic a0, a1;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        a0 = sda_line; wq();
        a1 = sda_line;
        m_scl = 1'b0; wq();
        acked = !a0 && !a1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        int base;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(sda_pull == 1'b0, "R9 pull", sda_pull, 0);
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(rx_valid == 1'b0, "R9 valid", rx_valid, 0);
        rst_n = 1'b1;
        wq();

        // R2 R3 sweep of every address with write bit 0
        for (int a = 0; a < 128; a++) begin
            bit match;
            match = (a == int'(DEV));
            base = ngot;
            start_cond();
            chk(busy == 1'b1, "R1 busy after start", busy, 1);
            send_byte({a[6:0], 1'b0}, ack);
            chk(ack == match, match ? "R2 addr ack" : "R3 addr nack", ack, match);
            chk(busy == match, match ? "R2 busy" : "R3 busy drop", busy, match);
            send_byte(8'(a) ^ 8'hA5, ack);
            chk(ack == match, "R6 R3 data ack", ack, match);
            chk(ngot - base == (match ? 1 : 0), "R5 R3 strobe count", ngot - base, match);
            if (match) chk(got[base] == (8'(a) ^ 8'hA5), "R5 data", got[base], 8'(a) ^ 8'hA5);
            stop_cond();
            chk(busy == 1'b0, "R1 busy after stop", busy, 0);
        end

        // R4 read bit set
        base = ngot;
        start_cond();
        send_byte({DEV, 1'b1}, ack);
        chk(ack == 1'b0, "R4 read nack", ack, 0);
        chk(busy == 1'b0, "R4 busy", busy, 0);
        send_byte(8'h00, ack);
        chk(ack == 1'b0, "R4 data nack", ack, 0);
        chk(ngot == base, "R4 no strobe", ngot - base, 0);
        stop_cond();

        // R6 R10 long stream of every byte value
        base = ngot;
        start_cond();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R2 stream addr", ack, 1);
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), ack);
            chk(ack, "R6 stream ack", ack, 1);
        end
        stop_cond();
        chk(ngot - base == 256, "R6 stream count", ngot - base, 256);
        for (int v = 0; v < 256; v++) begin
            if (base + v < 512)
                chk(got[base + v] == 8'(v), "R10 R5 stream data", got[base + v], v);
        end

        // R7 partial byte before stop
        base = ngot;
        start_cond();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hC3, ack);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        stop_cond();
        chk(ngot - base == 1, "R7 partial discarded", ngot - base, 1);
        chk(got[base] == 8'hC3, "R7 whole byte kept", got[base], 8'hC3);

        // R8 restart mid byte
        base = ngot;
        start_cond();
        send_byte({DEV, 1'b0}, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        start_cond();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R8 restart addr ack", ack, 1);
        send_byte(8'h3C, ack);
        stop_cond();
        chk(ngot - base == 1, "R8 restart count", ngot - base, 1);
        chk(got[base] == 8'h3C, "R8 restart data", got[base], 8'h3C);

        // R8 restart after a skipped transfer
        base = ngot;
        start_cond();
        send_byte({DEV ^ 7'h01, 1'b0}, ack);
        chk(!ack, "R3 other addr", ack, 0);
        start_cond();
        chk(busy, "R8 busy on restart", busy, 1);
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R8 ack after skip", ack, 1);
        send_byte(8'h81, ack);
        stop_cond();
        chk(ngot - base == 1 && got[base] == 8'h81, "R8 data after skip", got[base], 8'h81);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule